// File: doc/BRIEF.md
# Two-Byte Accumulator Processor Core

This block is a small 8-bit processor built around a single accumulator. It runs programs out of one byte-wide memory through an 8-bit address bus, separate read-data and write-data buses, active-low read and write strobes, and active-low enables that show when the core owns the address or data bus. Every instruction is two bytes long. The core fetches the opcode byte and then the operand byte. The operand is either the value itself (immediate mode) or a memory address that holds the value (indirect mode).

The core supports load, store, add, subtract, jump, compare-and-skip, flag set and flag toggle, plus a no-operation and a halt. It starts up by reading its first instruction address from the top byte of memory. A wait input lets the host freeze the core between instructions. The flag byte is driven on a port so that the surrounding logic can observe it.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low, `rd_n`, `wr_n`, `abe_n` and `dbe_n` are high and `status_o` is 0x00. In the first cycle after release, the core reads address 0xFF. The byte it reads there becomes the instruction pointer, so the next fetch comes from that address.
- R2: Each instruction takes two read cycles, at IP and then at IP+1. The opcode is split as group bits 7:6, mode bits 5:4 and operation bits 3:0. Opcodes 0x5n are immediate and 0x6n are indirect. Operations n = 0..7 are load, store, add, subtract, jump, skip-if-equal, set-flags and toggle-flags.
- R3: Load (0x50/0x60) places the operand value in A and updates Z and N. Store 0x51 writes A to the operand address. Store 0x61 writes A to the address held in the byte at the operand address.
- R4: Add (0x52/0x62) sets A to the sum modulo 256, with C = carry out, Z = result is zero and N = bit 7 of the result.
- R5: Subtract (0x53/0x63) sets A to A minus the value modulo 256, with C = 1 when no borrow occurs, Z = result is zero and N = bit 7 of the result.
- R6: Jump 0x54 loads IP with the operand. Jump 0x64 loads IP with the byte at the operand address.
- R7: Skip-if-equal (0x55/0x65) adds 2 to IP when A equals the value, which skips the next instruction. Otherwise execution continues in order.
- R8: `status_o` holds E at mask 0x08, N at 0x04, Z at 0x02 and C at 0x01, and bits 7:4 are always zero. Set-flags (0x56/0x66) ORs the value's low four bits into the flags. Toggle-flags (0x57/0x67) XORs them in.
- R9: Opcode 0x01 halts the core after its operand fetch, and no bus cycle follows until reset. Opcode 0x00 and every unlisted opcode (for example 0x58, 0x6C, 0x9F) consume two bytes and change neither A nor the flags.
- R10: When `wait_n` is low, the instruction in progress completes, including any store. The core then issues no bus cycle until `wait_n` returns high, and after that it resumes with the next instruction.
- R11: `abe_n` is low exactly in the cycles where `rd_n` or `wr_n` is low. `dbe_n` is low exactly in write cycles. `rd_n` and `wr_n` are never low together.
- R12: IP wraps modulo 256, so an instruction at 0xFE takes its operand from 0xFF, and the next instruction is fetched from 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_n | input | 1 | Pause request, active low |
| mem_addr | output | AW (8) | Memory address |
| mem_rdata | input | DW (8) | Read data, sampled at the end of a read cycle |
| mem_wdata | output | DW (8) | Write data (accumulator during a write) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low; memory stores on the rising edge |
| abe_n | output | 1 | Address bus owned by the core, active low |
| dbe_n | output | 1 | Data bus driven by the core, active low |
| status_o | output | DW (8) | Flag byte (E, N, Z, C in the low nibble) |

## Verification
The properties assume a memory that answers combinationally within the read cycle. They also assume that reset is held for at least two clock edges, so that the history behind each check starts inside reset. The wait-hold property further assumes that `wait_n` changes only between edges. The bench drives `rst_n` and `wait_n` only on falling edges and holds reset for several cycles before each program. It models memory as a combinational array that captures writes on the rising edge, which keeps every stimulus within these assumptions.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [2:0] {
      ST_VEC, ST_OPC, ST_ARG, ST_IND, ST_EXE, ST_WR, ST_HALT
   } state_e;

   typedef enum logic [3:0] {
      K_NOP, K_HLT, K_LDA, K_STA, K_ADD, K_SUB, K_JMP, K_SEQ, K_SFL, K_TGF
   } kind_e;

   typedef struct packed {
      logic [1:0] grp;
      logic [1:0] mode;
      logic [3:0] op;
   } opcode_t;

   localparam logic [3:0] NIB_SYS = 4'h0;
   localparam logic [3:0] NIB_IMM = 4'h5;
   localparam logic [3:0] NIB_IND = 4'h6;

   localparam int FLG_C = 0;
   localparam int FLG_Z = 1;
   localparam int FLG_N = 2;
   localparam int FLG_E = 3;
   localparam int NFLAGS = 4;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_cpu_pkg::*;
(
   input  logic [7:0] opc,
   output kind_e      kind,
   output logic       ind
);

   opcode_t o;

   always_comb begin
      o    = opcode_t'(opc);
      kind = K_NOP;
      ind  = 1'b0;
      case ({o.grp, o.mode})
         NIB_SYS: begin
            if (o.op == 4'h1) kind = K_HLT;
         end
         NIB_IMM, NIB_IND: begin
            ind = ({o.grp, o.mode} == NIB_IND);
            case (o.op)
               4'h0:    kind = K_LDA;
               4'h1:    kind = K_STA;
               4'h2:    kind = K_ADD;
               4'h3:    kind = K_SUB;
               4'h4:    kind = K_JMP;
               4'h5:    kind = K_SEQ;
               4'h6:    kind = K_SFL;
               4'h7:    kind = K_TGF;
               default: kind = K_NOP;
            endcase
            if (kind == K_NOP) ind = 1'b0;
         end
         default: kind = K_NOP;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int DW             = 8,
   parameter bit NOBORROW_CARRY = 1'b1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          sub,
   output logic [DW-1:0] res,
   output logic          cout
);

   logic [DW:0] sum;

   always_comb begin
      if (sub) sum = {1'b0, a} + {1'b0, ~b} + {{DW{1'b0}}, 1'b1};
      else     sum = {1'b0, a} + {1'b0, b};
   end

   assign res = sum[DW-1:0];

   generate
      if (NOBORROW_CARRY) begin : g_noborrow
         assign cout = sum[DW];
      end else begin : g_borrow
         assign cout = sub ? ~sum[DW] : sum[DW];
      end
   endgenerate

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int             DW             = 8,
   parameter int             AW             = 8,
   parameter logic [AW-1:0]  RESET_VEC      = '1,
   parameter bit             NOBORROW_CARRY = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wait_n,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] mem_wdata,
   output logic          rd_n,
   output logic          wr_n,
   output logic          abe_n,
   output logic          dbe_n,
   output logic [DW-1:0] status_o
);

   localparam logic [AW-1:0] IP_STEP = AW'(1);
   localparam logic [AW-1:0] IP_SKIP = AW'(2);

   generate
      if (AW != DW) begin : g_bad_aw
         $error("acc_cpu_core: AW must equal DW, since IP is loaded from a data byte");
      end
      if (DW < 8) begin : g_bad_dw
         $error("acc_cpu_core: DW must be at least 8 to hold an opcode");
      end
   endgenerate

   state_e               state;
   logic [AW-1:0]        ip;
   logic [DW-1:0]        acc;
   logic [DW-1:0]        opr;
   logic [7:0]           ir;
   logic [NFLAGS-1:0]    flags;

   kind_e                kind;
   logic                 ind;
   logic [DW-1:0]        alu_res;
   logic                 alu_c;

   acc_decode u_dec (
      .opc  (ir),
      .kind (kind),
      .ind  (ind)
   );

   acc_alu #(.DW(DW), .NOBORROW_CARRY(NOBORROW_CARRY)) u_alu (
      .a    (acc),
      .b    (opr),
      .sub  (kind == K_SUB),
      .res  (alu_res),
      .cout (alu_c)
   );

   logic rd_req, wr_req, bus_own;

   always_comb begin
      rd_req   = 1'b0;
      wr_req   = 1'b0;
      mem_addr = '0;
      if (rst_n) begin
         case (state)
            ST_VEC: begin rd_req = 1'b1; mem_addr = RESET_VEC; end
            ST_OPC: if (wait_n) begin rd_req = 1'b1; mem_addr = ip; end
            ST_ARG: begin rd_req = 1'b1; mem_addr = ip; end
            ST_IND: begin rd_req = 1'b1; mem_addr = opr[AW-1:0]; end
            ST_WR:  begin wr_req = 1'b1; mem_addr = opr[AW-1:0]; end
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_own = 1'b0;
      if (rst_n) begin
         bus_own = (state inside {ST_VEC, ST_ARG, ST_IND, ST_WR})
                   || (state == ST_OPC && wait_n);
      end
   end

   assign rd_n      = ~rd_req;
   assign wr_n      = ~wr_req;
   assign abe_n     = ~bus_own;
   assign dbe_n     = ~(rst_n && state == ST_WR);
   assign mem_wdata = wr_req ? acc : '0;
   assign status_o  = {{(DW-NFLAGS){1'b0}}, flags};

   state_e after_arg;

   always_comb begin
      case (kind)
         K_HLT:   after_arg = ST_HALT;
         K_NOP:   after_arg = ST_OPC;
         K_STA:   after_arg = ind ? ST_IND : ST_WR;
         default: after_arg = ind ? ST_IND : ST_EXE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_VEC;
         ip    <= '0;
         acc   <= '0;
         opr   <= '0;
         ir    <= '0;
         flags <= '0;
      end else begin
         case (state)
            ST_VEC: begin
               ip    <= mem_rdata[AW-1:0];
               state <= ST_OPC;
            end
            ST_OPC: begin
               if (wait_n) begin
                  ir    <= mem_rdata[7:0];
                  ip    <= ip + IP_STEP;
                  state <= ST_ARG;
               end
            end
            ST_ARG: begin
               opr   <= mem_rdata;
               ip    <= ip + IP_STEP;
               state <= after_arg;
            end
            ST_IND: begin
               opr   <= mem_rdata;
               state <= (kind == K_STA) ? ST_WR : ST_EXE;
            end
            ST_EXE: begin
               case (kind)
                  K_LDA: begin
                     acc          <= opr;
                     flags[FLG_Z] <= (opr == '0);
                     flags[FLG_N] <= opr[DW-1];
                  end
                  K_ADD, K_SUB: begin
                     acc          <= alu_res;
                     flags[FLG_C] <= alu_c;
                     flags[FLG_Z] <= (alu_res == '0);
                     flags[FLG_N] <= alu_res[DW-1];
                  end
                  K_JMP: ip <= opr[AW-1:0];
                  K_SEQ: if (acc == opr) ip <= ip + IP_SKIP;
                  K_SFL: flags <= flags | opr[NFLAGS-1:0];
                  K_TGF: flags <= flags ^ opr[NFLAGS-1:0];
                  default: ;
               endcase
               state <= ST_OPC;
            end
            ST_WR:   state <= ST_OPC;
            default: state <= ST_HALT;
         endcase
      end
   end

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk #(
   parameter int            DW        = 8,
   parameter int            AW        = 8,
   parameter logic [AW-1:0] RESET_VEC = '1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wait_n,
   input logic [AW-1:0] mem_addr,
   input logic          rd_n,
   input logic          wr_n,
   input logic          abe_n,
   input logic          dbe_n,
   input logic [DW-5:0] status_hi
);

   p_vector_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!rd_n && mem_addr == RESET_VEC))
      else $error("R1: first cycle after reset did not read the start vector");

   p_flag_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status_hi == '0)
      else $error("R8: status bits 7:4 not zero");

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n))
      else $error("R11: read and write strobes both active");

   p_abe_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
      abe_n == (rd_n && wr_n))
      else $error("R11: address enable disagrees with strobes");

   p_dbe_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dbe_n == wr_n)
      else $error("R11: data enable disagrees with write strobe");

   p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wait_n && $past(rst_n) && $past(rst_n, 2) && $past(abe_n) && $past(abe_n, 2))
      |-> abe_n)
      else $error("R10: bus cycle issued while paused");

endmodule

bind acc_cpu_core acc_cpu_core_chk #(
   .DW(DW), .AW(AW), .RESET_VEC(RESET_VEC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wait_n    (wait_n),
   .mem_addr  (mem_addr),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .abe_n     (abe_n),
   .dbe_n     (dbe_n),
   .status_hi (status_o[DW-1:4])
);

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wait_n = 1'b1;
   logic [7:0] mem_addr, mem_rdata, mem_wdata, status_o;
   logic       rd_n, wr_n, abe_n, dbe_n;

   logic [7:0] mem [256];

   int checks = 0;
   int errors = 0;
   int bus_viol = 0;

   always #5 clk = ~clk;

   acc_cpu_core dut (
      .clk(clk), .rst_n(rst_n), .wait_n(wait_n),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
      .rd_n(rd_n), .wr_n(wr_n), .abe_n(abe_n), .dbe_n(dbe_n),
      .status_o(status_o)
   );

   assign mem_rdata = mem[mem_addr];

   always @(posedge clk) begin
      if (rst_n && !wr_n) mem[mem_addr] <= mem_wdata;
   end

   // R11 monitor: enables must track the strobes in every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (abe_n != (rd_n & wr_n)) bus_viol++;
         if (dbe_n != wr_n) bus_viol++;
         if (!rd_n && !wr_n) bus_viol++;
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] a, input logic [7:0] d);
      mem[a] <= d;
   endtask

   task automatic put2(input logic [7:0] a, input logic [7:0] op, input logic [7:0] arg);
      mem[a] <= op;
      mem[a + 8'd1] <= arg;
   endtask

   task automatic clear_and_hold();
      @(negedge clk);
      rst_n  = 1'b0;
      wait_n = 1'b1;
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
   endtask

   task automatic go(input int n);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_r1();
      clear_and_hold();
      put(8'hFF, 8'h20);
      repeat (2) @(negedge clk);
      chk("R1 rd_n in reset", {7'd0, rd_n}, 8'h01);
      chk("R1 wr_n in reset", {7'd0, wr_n}, 8'h01);
      chk("R1 enables in reset", {6'd0, abe_n, dbe_n}, 8'h03);
      chk("R1 status in reset", status_o, 8'h00);
      rst_n = 1'b1;
      #1;
      chk("R1 vector address", mem_addr, 8'hFF);
      chk("R1 vector read", {7'd0, rd_n}, 8'h00);
      @(negedge clk);
      chk("R1 first fetch from vector", mem_addr, 8'h20);
   endtask

   task automatic t_fetch_r2();
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'h3C);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 opcode address", mem_addr, 8'h10);
      chk("R2 opcode read", {7'd0, rd_n}, 8'h00);
      @(negedge clk);
      chk("R2 operand address", mem_addr, 8'h11);
      chk("R2 operand read", {7'd0, rd_n}, 8'h00);
   endtask

   task automatic t_load_store_r3();
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'h3C);
      put2(8'h12, 8'h51, 8'h80);
      put2(8'h14, 8'h60, 8'h90);
      put2(8'h16, 8'h61, 8'h91);
      put2(8'h18, 8'h01, 8'h00);
      put(8'h90, 8'hA5);
      put(8'h91, 8'h82);
      go(80);
      chk("R3 store immediate", mem[8'h80], 8'h3C);
      chk("R3 store indirect", mem[8'h82], 8'hA5);
      chk("R3 pointer untouched", mem[8'h91], 8'h82);
      chk("R3 load sets N", status_o, 8'h04);
   endtask

   task automatic t_add_r4();
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'hF0);
      put2(8'h12, 8'h52, 8'h20);
      put2(8'h14, 8'h51, 8'h80);
      put2(8'h16, 8'h01, 8'h00);
      go(60);
      chk("R4 add sum", mem[8'h80], 8'h10);
      chk("R4 add carry", status_o, 8'h01);
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'h01);
      put2(8'h12, 8'h62, 8'h90);
      put2(8'h14, 8'h51, 8'h80);
      put2(8'h16, 8'h01, 8'h00);
      put(8'h80, 8'h55);
      put(8'h90, 8'hFF);
      go(60);
      chk("R4 add indirect sum", mem[8'h80], 8'h00);
      chk("R4 add carry and zero", status_o, 8'h03);
   endtask

   task automatic t_sub_r5();
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'h05);
      put2(8'h12, 8'h53, 8'h05);
      put2(8'h14, 8'h01, 8'h00);
      go(50);
      chk("R5 equal subtract flags", status_o, 8'h03);
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'h03);
      put2(8'h12, 8'h63, 8'h90);
      put2(8'h14, 8'h51, 8'h80);
      put2(8'h16, 8'h01, 8'h00);
      put(8'h90, 8'h05);
      go(60);
      chk("R5 borrow result", mem[8'h80], 8'hFE);
      chk("R5 borrow flags", status_o, 8'h04);
   endtask

   task automatic t_jump_r6();
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h54, 8'h20);
      put2(8'h12, 8'h50, 8'h11);
      put2(8'h14, 8'h51, 8'h80);
      put2(8'h20, 8'h50, 8'h22);
      put2(8'h22, 8'h51, 8'h80);
      put2(8'h24, 8'h01, 8'h00);
      go(60);
      chk("R6 jump immediate", mem[8'h80], 8'h22);
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h64, 8'h90);
      put2(8'h12, 8'h50, 8'h11);
      put2(8'h14, 8'h51, 8'h80);
      put2(8'h30, 8'h50, 8'h33);
      put2(8'h32, 8'h51, 8'h80);
      put2(8'h34, 8'h01, 8'h00);
      put(8'h90, 8'h30);
      go(60);
      chk("R6 jump indirect", mem[8'h80], 8'h33);
   endtask

   task automatic t_skip_r7();
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'h07);
      put2(8'h12, 8'h55, 8'h07);
      put2(8'h14, 8'h50, 8'h99);
      put2(8'h16, 8'h51, 8'h80);
      put2(8'h18, 8'h01, 8'h00);
      go(60);
      chk("R7 skip taken", mem[8'h80], 8'h07);
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'h07);
      put2(8'h12, 8'h65, 8'h90);
      put2(8'h14, 8'h50, 8'h99);
      put2(8'h16, 8'h51, 8'h80);
      put2(8'h18, 8'h01, 8'h00);
      put(8'h90, 8'h08);
      go(60);
      chk("R7 skip not taken", mem[8'h80], 8'h99);
   endtask

   task automatic t_flags_r8();
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h56, 8'hFF);
      put2(8'h12, 8'h01, 8'h00);
      go(40);
      chk("R8 set all flags, upper zero", status_o, 8'h0F);
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h56, 8'hFF);
      put2(8'h12, 8'h57, 8'h05);
      put2(8'h14, 8'h01, 8'h00);
      go(40);
      chk("R8 toggle mask", status_o, 8'h0A);
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h66, 8'h90);
      put2(8'h12, 8'h01, 8'h00);
      put(8'h90, 8'h08);
      go(40);
      chk("R8 set error flag indirect", status_o, 8'h08);
   endtask

   task automatic t_halt_nop_r9();
      int busy;
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'h44);
      put2(8'h12, 8'h01, 8'h00);
      put2(8'h14, 8'h51, 8'h80);
      go(30);
      busy = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (!abe_n || !rd_n || !wr_n) busy++;
      end
      chk("R9 no bus cycles after halt", busy[7:0], 8'h00);
      chk("R9 instruction after halt not run", mem[8'h80], 8'h00);
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'h44);
      put2(8'h12, 8'h00, 8'h00);
      put2(8'h14, 8'h58, 8'h12);
      put2(8'h16, 8'h6C, 8'h90);
      put2(8'h18, 8'h9F, 8'h00);
      put2(8'h1A, 8'h51, 8'h80);
      put2(8'h1C, 8'h01, 8'h00);
      put(8'h90, 8'hFF);
      go(80);
      chk("R9 unlisted opcodes leave A", mem[8'h80], 8'h44);
      chk("R9 unlisted opcodes leave flags", status_o, 8'h00);
   endtask

   task automatic t_wait_r10();
      bit hit;
      clear_and_hold();
      put(8'hFF, 8'h10);
      put2(8'h10, 8'h50, 8'h77);
      put2(8'h12, 8'h51, 8'h80);
      put2(8'h14, 8'h50, 8'h11);
      put2(8'h16, 8'h51, 8'h81);
      put2(8'h18, 8'h01, 8'h00);
      repeat (2) @(negedge clk);
      wait_n = 1'b0;
      rst_n  = 1'b1;
      repeat (15) @(negedge clk);
      chk("R10 paused from reset: bus idle", {7'd0, abe_n}, 8'h01);
      chk("R10 paused from reset: no store", mem[8'h80], 8'h00);
      wait_n = 1'b1;
      hit = 1'b0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (mem_addr == 8'h13 && !rd_n) begin
            hit = 1'b1;
            break;
         end
      end
      chk("R10 reached store operand", {7'd0, hit}, 8'h01);
      wait_n = 1'b0;
      repeat (12) @(negedge clk);
      chk("R10 current store completed", mem[8'h80], 8'h77);
      chk("R10 next store held", mem[8'h81], 8'h00);
      chk("R10 bus idle while paused", {7'd0, abe_n}, 8'h01);
      wait_n = 1'b1;
      repeat (40) @(negedge clk);
      chk("R10 resumed", mem[8'h81], 8'h11);
   endtask

   task automatic t_wrap_r12();
      clear_and_hold();
      put(8'hFF, 8'hFE);
      put(8'hFE, 8'h50);
      put2(8'h00, 8'h51, 8'h40);
      put2(8'h02, 8'h01, 8'h00);
      go(50);
      chk("R12 operand from FF, next at 00", mem[8'h40], 8'hFE);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset_r1();
      t_fetch_r2();
      t_load_store_r3();
      t_add_r4();
      t_sub_r5();
      t_jump_r6();
      t_skip_r7();
      t_flags_r8();
      t_halt_nop_r9();
      t_wait_r10();
      t_wrap_r12();
      chk("R11 bus enable consistency", bus_viol[7:0], 8'h00);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule